// File: doc/BRIEF.md
# Framed Serial Register Command Engine

This block sits between a byte-wide UART receiver and transmitter and the register logic of a device. On the receive side it hunts for a frame start byte. It then collects a command, a register address, a length and that many data bytes, followed by a two-byte checksum and a closing byte. Only a frame that passes every check is handed on. The handover is a one-cycle header strobe carrying the direction, address and length, followed by the data bytes on consecutive cycles. A damaged, truncated or unrecognised frame produces a one-cycle error pulse, and the receiver goes back to hunting.

On the transmit side the user latches a register address, a status byte and a length, and then supplies that many data bytes at any pace. The block then emits the complete response frame through a valid/ready byte interface, computing the checksum itself. Both directions buffer their data in a small memory that can be mapped to block RAM. A received frame is therefore released only after its checksum has been verified.

Top module: `sercmd_frame_engine`

## Requirements
- R1: While and directly after reset, req_hdr_valid, req_data_valid, frame_error, tx_valid and rsp_busy are all low.
- R2: A frame 0xDD, 0xA5 (read), address, length N, N data bytes, checksum high byte, checksum low byte, 0x77 produces one req_hdr_valid pulse with req_write=0 and the received address and length. The N data bytes then follow on req_data/req_data_valid in order, on the N consecutive cycles right after the header pulse.
- R3: The command byte 0x5A (write) gives the same delivery with req_write=1.
- R4: The checksum is the low 16 bits of 0x10000 minus the sum of the command, address, length and data bytes, sent high byte first. A frame whose checksum does not match gives a one-cycle frame_error pulse and no request.
- R5: A frame whose final byte is not 0x77 gives a frame_error pulse and no request.
- R6: A command byte other than 0xA5 or 0x5A gives a frame_error pulse and returns the parser to hunting, so a valid frame right afterwards is accepted.
- R7: A length byte above MAX_LEN gives a frame_error pulse and no request. A length equal to MAX_LEN is accepted.
- R8: While hunting, any byte other than 0xDD is dropped without an error and without a request.
- R9: Inside a frame, if no byte arrives for gap_limit clock cycles, the partial frame is dropped with a frame_error pulse. gap_limit = 0 disables this timeout.
- R10: After rsp_start and rsp_len data bytes, the transmitter emits 0xDD, address, status, length, data, checksum high, checksum low, 0x77. The checksum covers address, status, length and data, using the rule of R4.
- R11: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change.
- R12: rsp_start with rsp_len above MAX_LEN is ignored: rsp_busy stays low and no byte is sent.
- R13: Length zero is legal in both directions: a request header is given with no data beats, and a response consists of seven bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data holds a new byte this cycle |
| gap_limit | input | GAP_W | Inter-byte timeout in cycles, 0 disables it |
| req_hdr_valid | output | 1 | One-cycle strobe: an accepted request is being announced |
| req_write | output | 1 | 1 for a write command, 0 for a read command |
| req_addr | output | 8 | Register address of the request |
| req_len | output | 8 | Number of data bytes in the request |
| req_data | output | 8 | Request data byte |
| req_data_valid | output | 1 | req_data holds the next data byte |
| frame_error | output | 1 | One-cycle strobe: a frame was discarded |
| rsp_start | input | 1 | Latch a response header |
| rsp_addr | input | 8 | Response register address |
| rsp_status | input | 8 | Response status byte |
| rsp_len | input | 8 | Response data length |
| rsp_data | input | 8 | Response data byte |
| rsp_data_valid | input | 1 | rsp_data holds the next response byte |
| rsp_busy | output | 1 | A response is being collected or sent |
| tx_data | output | 8 | Byte to the UART transmitter |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Transmitter accepts tx_data this cycle |

## Verification
The bench targets the boundaries of the length field. It sends zero-length frames and frames of exactly MAX_LEN and MAX_LEN+1 bytes. A design with an off-by-one in the data counter would drop or repeat a data beat, or would accept the oversized frame. It corrupts the low checksum byte and the end byte separately, to catch a design that checks only one of them or that releases data before the checksum is known. It injects an unknown command followed immediately by a valid frame, and stray bytes before a frame, to expose a parser that fails to resynchronise or that treats idle noise as an error. It stalls mid-frame both with a timeout set and with the timeout disabled. It throttles tx_ready so that a transmitter which drops, repeats or changes a held byte produces a wrong response frame.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] FRAME_SOF  = 8'hDD;
  localparam logic [7:0] FRAME_EOF  = 8'h77;
  localparam logic [7:0] OP_READ    = 8'hA5;
  localparam logic [7:0] OP_WRITE   = 8'h5A;

  typedef enum logic [3:0] {
    RX_HUNT, RX_CMD, RX_ADDR, RX_LEN, RX_DATA,
    RX_CKH, RX_CKL, RX_END, RX_PLAY
  } rx_state_t;

  typedef enum logic [3:0] {
    TX_IDLE, TX_FILL, TX_SOF, TX_ADDR, TX_STAT, TX_LEN,
    TX_DATA, TX_CKH, TX_CKL, TX_EOF, TX_DONE
  } tx_state_t;
endpackage

// File: rtl/sfe_byte_ram.sv
module sfe_byte_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfe_gap_timer.sv
module sfe_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             kick,
  input  logic [GAP_W-1:0] limit,
  output logic             expire
);
  localparam logic [GAP_W-1:0] CNT_TOP = '1;

  logic [GAP_W-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm || kick) idle_cnt <= '0;
    else if (idle_cnt != CNT_TOP) idle_cnt <= idle_cnt + 1'b1;
  end

  assign expire = arm && !kick && (limit != '0) && (idle_cnt >= limit);
endmodule

// File: rtl/sfe_rx_parser.sv
module sfe_rx_parser
  import sfe_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int GAP_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic [GAP_W-1:0] gap_limit,
  output logic             req_hdr_valid,
  output logic             req_write,
  output logic [7:0]       req_addr,
  output logic [7:0]       req_len,
  output logic [7:0]       req_data,
  output logic             req_data_valid,
  output logic             frame_error
);
  localparam int         AW        = $clog2(MAX_LEN);
  localparam logic [7:0] LEN_LIMIT = 8'(MAX_LEN);

  rx_state_t   state;
  logic [15:0] run_sum;
  logic [7:0]  ck_hi, ck_lo;
  logic [7:0]  idx;
  logic        op_wr;
  logic [7:0]  hold_addr, hold_len;
  logic [15:0] ck_total;
  logic        armed, expire;
  logic        buf_we, buf_re;

  assign ck_total = run_sum + {ck_hi, ck_lo};
  assign armed    = (state != RX_HUNT) && (state != RX_PLAY);
  assign buf_we   = (state == RX_DATA) && rx_valid;
  assign buf_re   = (state == RX_PLAY) && (idx != hold_len);

  sfe_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk    (clk),
    .rst    (rst),
    .arm    (armed),
    .kick   (rx_valid),
    .limit  (gap_limit),
    .expire (expire)
  );

  sfe_byte_ram #(.DEPTH(MAX_LEN), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (idx[AW-1:0]),
    .wdata (rx_data),
    .re    (buf_re),
    .raddr (idx[AW-1:0]),
    .rdata (req_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= RX_HUNT;
      run_sum        <= '0;
      ck_hi          <= '0;
      ck_lo          <= '0;
      idx            <= '0;
      op_wr          <= 1'b0;
      hold_addr      <= '0;
      hold_len       <= '0;
      req_hdr_valid  <= 1'b0;
      req_write      <= 1'b0;
      req_addr       <= '0;
      req_len        <= '0;
      req_data_valid <= 1'b0;
      frame_error    <= 1'b0;
    end else begin
      req_hdr_valid  <= 1'b0;
      frame_error    <= 1'b0;
      req_data_valid <= buf_re;
      if (expire) begin
        frame_error <= 1'b1;
        state       <= RX_HUNT;
      end else begin
        case (state)
          RX_HUNT: if (rx_valid && rx_data == FRAME_SOF) begin
            run_sum <= '0;
            idx     <= '0;
            state   <= RX_CMD;
          end
          RX_CMD: if (rx_valid) begin
            if (rx_data == OP_READ || rx_data == OP_WRITE) begin
              op_wr   <= (rx_data == OP_WRITE);
              run_sum <= run_sum + {8'h00, rx_data};
              state   <= RX_ADDR;
            end else begin
              frame_error <= 1'b1;
              state       <= RX_HUNT;
            end
          end
          RX_ADDR: if (rx_valid) begin
            hold_addr <= rx_data;
            run_sum   <= run_sum + {8'h00, rx_data};
            state     <= RX_LEN;
          end
          RX_LEN: if (rx_valid) begin
            if (rx_data > LEN_LIMIT) begin
              frame_error <= 1'b1;
              state       <= RX_HUNT;
            end else begin
              hold_len <= rx_data;
              run_sum  <= run_sum + {8'h00, rx_data};
              state    <= (rx_data == 8'd0) ? RX_CKH : RX_DATA;
            end
          end
          RX_DATA: if (rx_valid) begin
            run_sum <= run_sum + {8'h00, rx_data};
            idx     <= idx + 8'd1;
            if (idx == hold_len - 8'd1) state <= RX_CKH;
          end
          RX_CKH: if (rx_valid) begin
            ck_hi <= rx_data;
            state <= RX_CKL;
          end
          RX_CKL: if (rx_valid) begin
            ck_lo <= rx_data;
            state <= RX_END;
          end
          RX_END: if (rx_valid) begin
            if (rx_data == FRAME_EOF && ck_total == 16'h0000) begin
              req_hdr_valid <= 1'b1;
              req_write     <= op_wr;
              req_addr      <= hold_addr;
              req_len       <= hold_len;
              idx           <= '0;
              state         <= RX_PLAY;
            end else begin
              frame_error <= 1'b1;
              state       <= RX_HUNT;
            end
          end
          RX_PLAY: begin
            if (idx == hold_len) state <= RX_HUNT;
            else idx <= idx + 8'd1;
          end
          default: state <= RX_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/sfe_tx_builder.sv
module sfe_tx_builder
  import sfe_pkg::*;
#(
  parameter int MAX_LEN = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rsp_start,
  input  logic [7:0] rsp_addr,
  input  logic [7:0] rsp_status,
  input  logic [7:0] rsp_len,
  input  logic [7:0] rsp_data,
  input  logic       rsp_data_valid,
  output logic       rsp_busy,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready
);
  localparam int         AW        = $clog2(MAX_LEN);
  localparam logic [7:0] LEN_LIMIT = 8'(MAX_LEN);

  tx_state_t   state;
  logic [7:0]  h_addr, h_stat, h_len, idx;
  logic [15:0] run_sum, ck_word;
  logic        advance, buf_we, buf_re;
  logic [AW-1:0] rd_ptr;
  logic [7:0]  buf_q;

  assign ck_word = 16'h0000 - run_sum;
  assign advance = !tx_valid || tx_ready;
  assign buf_we  = (state == TX_FILL) && rsp_data_valid;
  assign buf_re  = advance && ((state == TX_LEN) ||
                   ((state == TX_DATA) && (idx != h_len - 8'd1)));
  assign rd_ptr  = (state == TX_LEN) ? '0
                 : idx[AW-1:0] + {{(AW-1){1'b0}}, 1'b1};

  sfe_byte_ram #(.DEPTH(MAX_LEN), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (idx[AW-1:0]),
    .wdata (rsp_data),
    .re    (buf_re),
    .raddr (rd_ptr),
    .rdata (buf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      h_addr   <= '0;
      h_stat   <= '0;
      h_len    <= '0;
      idx      <= '0;
      run_sum  <= '0;
      rsp_busy <= 1'b0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: if (rsp_start && rsp_len <= LEN_LIMIT) begin
          h_addr   <= rsp_addr;
          h_stat   <= rsp_status;
          h_len    <= rsp_len;
          idx      <= '0;
          run_sum  <= {8'h00, rsp_addr} + {8'h00, rsp_status} + {8'h00, rsp_len};
          rsp_busy <= 1'b1;
          state    <= (rsp_len == 8'd0) ? TX_SOF : TX_FILL;
        end
        TX_FILL: if (rsp_data_valid) begin
          run_sum <= run_sum + {8'h00, rsp_data};
          idx     <= idx + 8'd1;
          if (idx == h_len - 8'd1) state <= TX_SOF;
        end
        TX_SOF: if (advance) begin
          tx_data  <= FRAME_SOF;
          tx_valid <= 1'b1;
          state    <= TX_ADDR;
        end
        TX_ADDR: if (advance) begin
          tx_data <= h_addr;
          state   <= TX_STAT;
        end
        TX_STAT: if (advance) begin
          tx_data <= h_stat;
          state   <= TX_LEN;
        end
        TX_LEN: if (advance) begin
          tx_data <= h_len;
          idx     <= '0;
          state   <= (h_len == 8'd0) ? TX_CKH : TX_DATA;
        end
        TX_DATA: if (advance) begin
          tx_data <= buf_q;
          if (idx == h_len - 8'd1) state <= TX_CKH;
          else idx <= idx + 8'd1;
        end
        TX_CKH: if (advance) begin
          tx_data <= ck_word[15:8];
          state   <= TX_CKL;
        end
        TX_CKL: if (advance) begin
          tx_data <= ck_word[7:0];
          state   <= TX_EOF;
        end
        TX_EOF: if (advance) begin
          tx_data <= FRAME_EOF;
          state   <= TX_DONE;
        end
        TX_DONE: if (tx_ready) begin
          tx_valid <= 1'b0;
          rsp_busy <= 1'b0;
          state    <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sercmd_frame_engine.sv
module sercmd_frame_engine #(
  parameter int MAX_LEN = 32,
  parameter int GAP_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic [GAP_W-1:0] gap_limit,
  output logic             req_hdr_valid,
  output logic             req_write,
  output logic [7:0]       req_addr,
  output logic [7:0]       req_len,
  output logic [7:0]       req_data,
  output logic             req_data_valid,
  output logic             frame_error,
  input  logic             rsp_start,
  input  logic [7:0]       rsp_addr,
  input  logic [7:0]       rsp_status,
  input  logic [7:0]       rsp_len,
  input  logic [7:0]       rsp_data,
  input  logic             rsp_data_valid,
  output logic             rsp_busy,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready
);
  sfe_rx_parser #(.MAX_LEN(MAX_LEN), .GAP_W(GAP_W)) u_rx (
    .clk            (clk),
    .rst            (rst),
    .rx_data        (rx_data),
    .rx_valid       (rx_valid),
    .gap_limit      (gap_limit),
    .req_hdr_valid  (req_hdr_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_len        (req_len),
    .req_data       (req_data),
    .req_data_valid (req_data_valid),
    .frame_error    (frame_error)
  );

  sfe_tx_builder #(.MAX_LEN(MAX_LEN)) u_tx (
    .clk            (clk),
    .rst            (rst),
    .rsp_start      (rsp_start),
    .rsp_addr       (rsp_addr),
    .rsp_status     (rsp_status),
    .rsp_len        (rsp_len),
    .rsp_data       (rsp_data),
    .rsp_data_valid (rsp_data_valid),
    .rsp_busy       (rsp_busy),
    .tx_data        (tx_data),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready)
  );
endmodule

// File: rtl/sfe_frame_checker.sv
module sfe_frame_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_hdr_valid,
  input logic [7:0] req_len,
  input logic       req_data_valid,
  input logic       frame_error,
  input logic       rsp_busy,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready
);
  logic [7:0] beat_cnt;

  always_ff @(posedge clk) begin
    if (rst) beat_cnt <= '0;
    else if (req_hdr_valid) beat_cnt <= '0;
    else if (req_data_valid) beat_cnt <= beat_cnt + 8'd1;
  end

  // R1: quiet outputs in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!req_hdr_valid && !req_data_valid && !frame_error && !tx_valid && !rsp_busy));

  // R2: data beats start in the cycle after a header with nonzero length
  a_r2_data_follows_hdr: assert property (@(posedge clk) disable iff (rst)
    (req_hdr_valid && req_len != 8'd0) |=> req_data_valid);

  // R2: never more data beats than announced
  a_r2_beats_bounded: assert property (@(posedge clk) disable iff (rst)
    req_data_valid |-> (beat_cnt < req_len));

  // R4: error and acceptance are exclusive, and an error lasts one cycle
  a_r4_err_excl: assert property (@(posedge clk) disable iff (rst)
    frame_error |-> !req_hdr_valid);
  a_r4_err_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_error |=> !frame_error);

  // R10: every response frame opens with the start byte
  a_r10_opens_with_sof: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> (tx_data == 8'hDD));

  // R11: a held byte is not withdrawn or changed
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind sercmd_frame_engine sfe_frame_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_hdr_valid  (req_hdr_valid),
  .req_len        (req_len),
  .req_data_valid (req_data_valid),
  .frame_error    (frame_error),
  .rsp_busy       (rsp_busy),
  .tx_data        (tx_data),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready)
);

// File: tb/tb_sercmd_frame_engine.sv
module tb_sercmd_frame_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN    = 32;
  localparam int GAP_W      = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0;
  logic [GAP_W-1:0] gap_limit = 16'd20;
  logic req_hdr_valid, req_write, req_data_valid, frame_error;
  logic [7:0] req_addr, req_len, req_data;
  logic rsp_start = 1'b0;
  logic [7:0] rsp_addr = '0, rsp_status = '0, rsp_len = '0, rsp_data = '0;
  logic rsp_data_valid = 1'b0;
  logic rsp_busy;
  logic [7:0] tx_data;
  logic tx_valid, tx_ready;

  int cyc = 0;
  int n_checks = 0, n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tx_ready = (cyc % 3) != 2;

  sercmd_frame_engine #(.MAX_LEN(MAX_LEN), .GAP_W(GAP_W)) dut (.*);

  // capture
  int n_hdr = 0, n_dat = 0, n_err = 0, n_tx = 0, hdr_cyc = 0;
  int tim_bad = 0, hold_bad = 0;
  logic [7:0] m_addr, m_len, m_dat [64], tx_cap [64], exp_dat [64], exp_tx [64];
  logic m_wr;
  logic p_stall = 1'b0;
  logic [7:0] p_byte = '0;

  always @(negedge clk) begin
    if (req_hdr_valid) begin
      n_hdr++; m_addr = req_addr; m_len = req_len; m_wr = req_write;
      n_dat = 0; hdr_cyc = cyc;
    end
    if (req_data_valid) begin
      if (cyc != hdr_cyc + 1 + n_dat) tim_bad++;
      if (n_dat < 64) m_dat[n_dat] = req_data;
      n_dat++;
    end
    if (frame_error) n_err++;
    if (p_stall && (!tx_valid || tx_data != p_byte)) hold_bad++;
    p_stall = tx_valid && !tx_ready;
    p_byte  = tx_data;
    if (tx_valid && tx_ready) begin
      if (n_tx < 64) tx_cap[n_tx] = tx_data;
      n_tx++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_data = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] cmd, input logic [7:0] addr, input int len,
                            input logic [7:0] seed, input logic [7:0] ckx, input logic [7:0] eofb);
    logic [15:0] s, ck;
    logic [7:0] b;
    s = {8'h00, cmd} + {8'h00, addr} + 16'(len);
    send_byte(8'hDD); send_byte(cmd); send_byte(addr); send_byte(8'(len));
    for (int i = 0; i < len; i++) begin
      b = seed + 8'(i * 7);
      if (i < 64) exp_dat[i] = b;
      s = s + {8'h00, b};
      send_byte(b);
    end
    ck = 16'h0000 - s;
    send_byte(ck[15:8]); send_byte(ck[7:0] ^ ckx); send_byte(eofb);
    repeat (MAX_LEN + 8) @(negedge clk);
  endtask

  task automatic expect_req(input string tag, input int h0, input int e0,
                            input logic wr, input logic [7:0] addr, input int len);
    int bad = 0;
    chk(n_hdr == h0 + 1, {tag, " header count"}, n_hdr - h0, 1);
    chk(n_err == e0, {tag, " no error"}, n_err - e0, 0);
    chk(m_wr == wr && m_addr == addr && m_len == 8'(len), {tag, " header fields"},
        {m_wr, m_addr, m_len}, {wr, addr, 8'(len)});
    chk(n_dat == len, {tag, " data beats"}, n_dat, len);
    for (int i = 0; i < len && i < 64; i++) if (m_dat[i] != exp_dat[i]) bad++;
    chk(bad == 0 && tim_bad == 0, {tag, " data order and timing"}, bad + tim_bad, 0);
  endtask

  task automatic t_reset;
    chk(!req_hdr_valid && !req_data_valid && !frame_error && !tx_valid && !rsp_busy,
        "R1 reset state", {req_hdr_valid, req_data_valid, frame_error, tx_valid, rsp_busy}, 0);
  endtask

  task automatic t_read;
    int h0 = n_hdr, e0 = n_err;
    send_frame(8'hA5, 8'h03, 3, 8'h10, 8'h00, 8'h77);
    expect_req("R2 read", h0, e0, 1'b0, 8'h03, 3);
  endtask

  task automatic t_write;
    int h0 = n_hdr, e0 = n_err;
    send_frame(8'h5A, 8'h2D, 5, 8'h41, 8'h00, 8'h77);
    expect_req("R3 write", h0, e0, 1'b1, 8'h2D, 5);
  endtask

  task automatic t_zero_len;
    int h0 = n_hdr, e0 = n_err;
    send_frame(8'hA5, 8'h04, 0, 8'h00, 8'h00, 8'h77);
    expect_req("R13 zero length request", h0, e0, 1'b0, 8'h04, 0);
  endtask

  task automatic t_bad_ck;
    int h0 = n_hdr, e0 = n_err;
    send_frame(8'h5A, 8'h10, 4, 8'h20, 8'h01, 8'h77);
    chk(n_err == e0 + 1 && n_hdr == h0, "R4 checksum mismatch", n_err - e0, 1);
  endtask

  task automatic t_bad_eof;
    int h0 = n_hdr, e0 = n_err;
    send_frame(8'hA5, 8'h11, 2, 8'h30, 8'h00, 8'h78);
    chk(n_err == e0 + 1 && n_hdr == h0, "R5 wrong end byte", n_err - e0, 1);
  endtask

  task automatic t_bad_cmd;
    int h0 = n_hdr, e0 = n_err;
    send_byte(8'hDD); send_byte(8'h11);
    repeat (4) @(negedge clk);
    chk(n_err == e0 + 1, "R6 unknown command flagged", n_err - e0, 1);
    send_frame(8'h5A, 8'h22, 2, 8'h05, 8'h00, 8'h77);
    expect_req("R6 resync after unknown command", h0, e0 + 1, 1'b1, 8'h22, 2);
  endtask

  task automatic t_lengths;
    int h0 = n_hdr, e0 = n_err;
    send_frame(8'h5A, 8'h30, MAX_LEN, 8'h02, 8'h00, 8'h77);
    expect_req("R7 maximum length", h0, e0, 1'b1, 8'h30, MAX_LEN);
    h0 = n_hdr; e0 = n_err;
    send_frame(8'h5A, 8'h31, MAX_LEN + 1, 8'h01, 8'h00, 8'h77);
    chk(n_err >= e0 + 1 && n_hdr == h0, "R7 oversized length rejected", n_hdr - h0, 0);
  endtask

  task automatic t_noise;
    int h0 = n_hdr, e0 = n_err;
    send_byte(8'h00); send_byte(8'h77); send_byte(8'hA5); send_byte(8'h5A);
    chk(n_err == e0 && n_hdr == h0, "R8 idle noise silent", n_err - e0, 0);
    send_frame(8'hA5, 8'h40, 1, 8'h09, 8'h00, 8'h77);
    expect_req("R8 frame after noise", h0, e0, 1'b0, 8'h40, 1);
  endtask

  task automatic t_timeout;
    int h0 = n_hdr, e0 = n_err;
    logic [15:0] s, ck;
    send_byte(8'hDD); send_byte(8'hA5); send_byte(8'h01);
    repeat (40) @(negedge clk);
    chk(n_err == e0 + 1 && n_hdr == h0, "R9 stall aborts frame", n_err - e0, 1);
    gap_limit = '0;
    h0 = n_hdr; e0 = n_err;
    send_byte(8'hDD); send_byte(8'h5A); send_byte(8'h07); send_byte(8'h02);
    repeat (100) @(negedge clk);
    chk(n_err == e0, "R9 timeout disabled", n_err - e0, 0);
    exp_dat[0] = 8'hC3; exp_dat[1] = 8'h3C;
    send_byte(8'hC3); send_byte(8'h3C);
    s = 16'h5A + 16'h07 + 16'h02 + 16'hC3 + 16'h3C;
    ck = 16'h0000 - s;
    send_byte(ck[15:8]); send_byte(ck[7:0]); send_byte(8'h77);
    repeat (10) @(negedge clk);
    expect_req("R9 stalled frame completes", h0, e0, 1'b1, 8'h07, 2);
    gap_limit = 16'd20;
  endtask

  task automatic run_rsp(input string tag, input logic [7:0] a, input logic [7:0] st, input int len);
    logic [15:0] s, ck;
    int t0, bad, k;
    t0 = n_tx;
    @(negedge clk);
    rsp_start = 1'b1; rsp_addr = a; rsp_status = st; rsp_len = 8'(len);
    @(negedge clk); rsp_start = 1'b0;
    s = {8'h00, a} + {8'h00, st} + 16'(len);
    exp_tx[0] = 8'hDD; exp_tx[1] = a; exp_tx[2] = st; exp_tx[3] = 8'(len);
    for (int i = 0; i < len; i++) begin
      rsp_data = 8'h90 + 8'(i * 13); rsp_data_valid = 1'b1;
      exp_tx[4 + i] = rsp_data; s = s + {8'h00, rsp_data};
      @(negedge clk); rsp_data_valid = 1'b0;
      @(negedge clk);
    end
    ck = 16'h0000 - s;
    exp_tx[4 + len] = ck[15:8]; exp_tx[5 + len] = ck[7:0]; exp_tx[6 + len] = 8'h77;
    k = 0;
    while (rsp_busy && k < 500) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
    chk(n_tx - t0 == len + 7, {tag, " byte count"}, n_tx - t0, len + 7);
    bad = 0;
    for (int i = 0; i < len + 7; i++) if (tx_cap[t0 + i] != exp_tx[i]) bad++;
    chk(bad == 0, {tag, " byte sequence"}, bad, 0);
  endtask

  task automatic t_response;
    run_rsp("R10 response data", 8'h2A, 8'h00, 4);
    chk(hold_bad == 0, "R11 held byte stable", hold_bad, 0);
    run_rsp("R13 zero length response", 8'h05, 8'h80, 0);
  endtask

  task automatic t_rsp_oversize;
    int t0 = n_tx, busy_seen = 0;
    @(negedge clk);
    rsp_start = 1'b1; rsp_len = 8'(MAX_LEN + 1); rsp_addr = 8'h01;
    @(negedge clk); rsp_start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (rsp_busy) busy_seen++;
      @(negedge clk);
    end
    chk(busy_seen == 0 && n_tx == t0, "R12 oversized response ignored", busy_seen + n_tx - t0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_zero_len();
    t_bad_ck();
    t_bad_eof();
    t_bad_cmd();
    t_lengths();
    t_noise();
    t_timeout();
    t_response();
    t_rsp_oversize();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule